// File: doc/BRIEF.md
# Program-Memory Table Access Unit

This unit lets a 16-bit data path read and modify a program store whose words are 24 bits wide. A request carries an 8-bit page value and a 16-bit effective address; together they form a 24-bit table address. Program words sit two address units apart, so bit 0 of the effective address never chooses a word. In byte mode it chooses one of two bytes. The top bit of the page chooses between a user region and a configuration region. Each region is modelled as a small internal array of 24-bit words.

Four operations exist. Two read the low 16 bits or the high 8 bits of a word. Two write those same fields. Each operation runs in word mode or in byte mode. The high field is only 8 bits wide, so the upper half of the data bus maps onto a byte that does not exist. That byte always reads as zero, and writes to it are discarded. A write to the configuration region needs a separate enable input; without it, the write is dropped and an error pulse is raised.

A request is taken in one cycle and answered one cycle later through a registered response. A write and a read issued on consecutive cycles see each other's effect.

Top module: `tbl_access_unit`

## Requirements
- R1: While reset is asserted and after its release, `rsp_valid` and `wr_err` are 0 and `rsp_rdata` is 0 until the first request.
- R2: A request with `req_valid`=1 at a rising edge gives `rsp_valid`=1 for exactly the following cycle, with `rsp_cfg_space` equal to page bit 7 of that request. Operation codes on `req_op` are: 2'b00 read low, 2'b01 read high, 2'b10 write low, 2'b11 write high (bit 1 = write, bit 0 = high field).
- R3: The word is chosen by effective-address bits [IDX_W:1] within the region chosen by page bit 7. Page bits 6:0, effective-address bits above IDX_W, and (in word mode) effective-address bit 0 have no effect. The two regions are separate arrays.
- R4: A word-mode low read returns program bits 15:0 on `rsp_rdata[15:0]`.
- R5: A byte-mode low read returns program bits 15:8 when address bit 0 is 1, and bits 7:0 when it is 0. The byte is placed in `rsp_rdata[7:0]`, and `rsp_rdata[15:8]` is 0.
- R6: A word-mode high read returns program bits 23:16 in `rsp_rdata[7:0]`, with `rsp_rdata[15:8]` = 0.
- R7: A byte-mode high read returns program bits 23:16 in `rsp_rdata[7:0]` when address bit 0 is 0. When address bit 0 is 1 it returns all zeros.
- R8: A word-mode low write replaces program bits 15:0 with `wdata`. A byte-mode low write replaces only bits 15:8 (address bit 0 = 1) or bits 7:0 (address bit 0 = 0) with `wdata[7:0]`.
- R9: A high write in word mode, or in byte mode with address bit 0 = 0, replaces program bits 23:16 with `wdata[7:0]`. A byte-mode high write with address bit 0 = 1 leaves the word unchanged.
- R10: A write with page bit 7 = 1 while `cfg_wr_en` = 0 changes nothing and raises `wr_err` for exactly the response cycle. `wr_err` is 0 in every other cycle.
- R11: The response to a write carries `rsp_rdata` = 0, and a read issued in the cycle after a write sees the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one operation per cycle |
| req_op | input | 2 | Operation: bit 1 write, bit 0 high field |
| req_byte | input | 1 | 1 = byte mode, 0 = word mode |
| req_page | input | 8 | Page value; bit 7 selects configuration region |
| req_ea | input | 16 | Effective address from the data path |
| req_wdata | input | 16 | Write data |
| cfg_wr_en | input | 1 | Permits writes to the configuration region |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 16 | Read result; 0 for writes |
| rsp_cfg_space | output | 1 | Region of the answered request |
| wr_err | output | 1 | Pulse for a dropped configuration write |

## Verification
The hardest case to reach is a store that an operation must leave alone. This covers a write to the missing upper byte, and a configuration write without permission. Both respond normally, so the unchanged word shows only on a later read. The sweep walks every operation, mode, byte select, region and word index, with the enable both off and on. After every write it reads the full word back through the low and high word paths and compares it against a bench model. The page and upper address bits vary throughout, so any dependence on them shows up as a miscompare.

// File: rtl/tbl_pkg.sv
package tbl_pkg;

  typedef enum logic [1:0] {
    OP_RD_LO = 2'b00,
    OP_RD_HI = 2'b01,
    OP_WR_LO = 2'b10,
    OP_WR_HI = 2'b11
  } tbl_op_e;

  localparam int NUM_SPACES = 2;

endpackage

// File: rtl/tbl_addr_map.sv
module tbl_addr_map #(
  parameter int IDX_W = 4
) (
  input  logic             page_msb,
  input  logic [IDX_W:0]   ea_low,
  input  logic             byte_mode,
  output logic             cfg_space,
  output logic [IDX_W-1:0] word_idx,
  output logic             byte_hi
);

  always_comb begin
    cfg_space = page_msb;
    word_idx  = ea_low[IDX_W:1];
    byte_hi   = byte_mode & ea_low[0];
  end

endmodule

// File: rtl/tbl_lane_mux.sv
module tbl_lane_mux #(
  parameter int DATA_W = 16,
  parameter int PROG_W = 24
) (
  input  logic              op_hi,
  input  logic              byte_mode,
  input  logic              byte_hi,
  input  logic [PROG_W-1:0] word,
  output logic [DATA_W-1:0] rdata
);

  localparam int BYTE_W = DATA_W / 2;
  localparam int HI_W   = PROG_W - DATA_W;

  always_comb begin
    rdata = '0;
    if (!op_hi) begin
      if (!byte_mode) begin
        rdata = word[DATA_W-1:0];
      end else if (byte_hi) begin
        rdata[BYTE_W-1:0] = word[DATA_W-1:BYTE_W];
      end else begin
        rdata[BYTE_W-1:0] = word[BYTE_W-1:0];
      end
    end else if (!(byte_mode && byte_hi)) begin
      rdata[HI_W-1:0] = word[PROG_W-1:DATA_W];
    end
  end

endmodule

// File: rtl/tbl_lane_merge.sv
module tbl_lane_merge #(
  parameter int DATA_W = 16,
  parameter int PROG_W = 24
) (
  input  logic              op_hi,
  input  logic              byte_mode,
  input  logic              byte_hi,
  input  logic [PROG_W-1:0] old_word,
  input  logic [DATA_W-1:0] wdata,
  output logic [PROG_W-1:0] new_word,
  output logic              touches
);

  localparam int BYTE_W = DATA_W / 2;
  localparam int HI_W   = PROG_W - DATA_W;

  always_comb begin
    new_word = old_word;
    touches  = 1'b1;
    if (!op_hi) begin
      if (!byte_mode) begin
        new_word[DATA_W-1:0] = wdata;
      end else if (byte_hi) begin
        new_word[DATA_W-1:BYTE_W] = wdata[BYTE_W-1:0];
      end else begin
        new_word[BYTE_W-1:0] = wdata[BYTE_W-1:0];
      end
    end else if (byte_mode && byte_hi) begin
      touches = 1'b0;
    end else begin
      new_word[PROG_W-1:DATA_W] = wdata[HI_W-1:0];
    end
  end

endmodule

// File: rtl/tbl_word_store.sv
module tbl_word_store #(
  parameter int PROG_W = 24,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              space,
  input  logic [IDX_W-1:0]  idx,
  input  logic [PROG_W-1:0] wr_word,
  output logic [PROG_W-1:0] rd_word
);

  localparam int DEPTH = 1 << IDX_W;

  logic [PROG_W-1:0] bank_rd [tbl_pkg::NUM_SPACES];

  for (genvar s = 0; s < tbl_pkg::NUM_SPACES; s++) begin : g_space
    logic [PROG_W-1:0] mem [DEPTH];
    logic              bank_we;

    always_comb begin
      bank_we = wr_en && (space == 1'(s));
    end

    always_ff @(posedge clk) begin
      if (bank_we) begin
        mem[idx] <= wr_word;
      end
    end

    always_comb begin
      bank_rd[s] = mem[idx];
    end
  end

  always_comb begin
    rd_word = bank_rd[space];
  end

endmodule

// File: rtl/tbl_access_unit.sv
module tbl_access_unit #(
  parameter int PAGE_W = 8,
  parameter int EA_W   = 16,
  parameter int DATA_W = 16,
  parameter int PROG_W = 24,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_byte,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [EA_W-1:0]   req_ea,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cfg_wr_en,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_cfg_space,
  output logic              wr_err
);

  logic              cfg_space;
  logic [IDX_W-1:0]  word_idx;
  logic              byte_hi;
  logic [PROG_W-1:0] cur_word;
  logic [PROG_W-1:0] merged_word;
  logic              lane_touch;
  logic [DATA_W-1:0] lane_rdata;
  logic              is_wr;
  logic              op_hi;
  logic              wr_blocked;
  logic              store_we;
  logic              unused_addr_bits;

  logic              valid_d, valid_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              space_d, space_q;
  logic              err_d,   err_q;

  always_comb begin
    unused_addr_bits = ^{req_page[PAGE_W-2:0], req_ea[EA_W-1:IDX_W+1]};
  end

  tbl_addr_map #(.IDX_W(IDX_W)) u_addr (
    .page_msb (req_page[PAGE_W-1]),
    .ea_low   (req_ea[IDX_W:0]),
    .byte_mode(req_byte),
    .cfg_space(cfg_space),
    .word_idx (word_idx),
    .byte_hi  (byte_hi)
  );

  tbl_word_store #(.PROG_W(PROG_W), .IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .wr_en  (store_we),
    .space  (cfg_space),
    .idx    (word_idx),
    .wr_word(merged_word),
    .rd_word(cur_word)
  );

  tbl_lane_mux #(.DATA_W(DATA_W), .PROG_W(PROG_W)) u_rd (
    .op_hi    (op_hi),
    .byte_mode(req_byte),
    .byte_hi  (byte_hi),
    .word     (cur_word),
    .rdata    (lane_rdata)
  );

  tbl_lane_merge #(.DATA_W(DATA_W), .PROG_W(PROG_W)) u_wr (
    .op_hi    (op_hi),
    .byte_mode(req_byte),
    .byte_hi  (byte_hi),
    .old_word (cur_word),
    .wdata    (req_wdata),
    .new_word (merged_word),
    .touches  (lane_touch)
  );

  // Request decode and next-state values
  always_comb begin
    is_wr      = req_op[1];
    op_hi      = req_op[0];
    wr_blocked = cfg_space && !cfg_wr_en;
    store_we   = req_valid && is_wr && !wr_blocked && lane_touch;
    valid_d    = req_valid;
    err_d      = req_valid && is_wr && wr_blocked;
    rdata_d    = (req_valid && !is_wr) ? lane_rdata : '0;
    space_d    = req_valid ? cfg_space : space_q;
  end

  // Response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rdata_q <= '0;
      space_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
      if (req_valid) begin
        space_q <= space_d;
      end
    end
  end

  always_comb begin
    rsp_valid     = valid_q;
    rsp_rdata     = rdata_q;
    rsp_cfg_space = space_q;
    wr_err        = err_q;
  end

endmodule

// File: rtl/tbl_access_chk.sv
module tbl_access_chk #(
  parameter int PAGE_W = 8,
  parameter int EA_W   = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              req_byte,
  input logic [PAGE_W-1:0] req_page,
  input logic [EA_W-1:0]   req_ea,
  input logic              cfg_wr_en,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_cfg_space,
  input logic              wr_err
);

  localparam int BYTE_W = DATA_W / 2;

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (!rsp_valid && !wr_err && rsp_rdata == '0);
    end
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_space_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_cfg_space == $past(req_page[PAGE_W-1]));

  assert_byte_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_op[1] && req_byte) |=> rsp_rdata[DATA_W-1:BYTE_W] == '0);

  assert_hi_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b01) |=> rsp_rdata[DATA_W-1:BYTE_W] == '0);

  assert_phantom_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b01 && req_byte && req_ea[0]) |=> rsp_rdata == '0);

  assert_err_raised_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op[1] && req_page[PAGE_W-1] && !cfg_wr_en) |=> wr_err);

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_op[1] && req_page[PAGE_W-1] && !cfg_wr_en) |=> !wr_err);

  assert_wr_rdata_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op[1]) |=> rsp_rdata == '0);

endmodule

bind tbl_access_unit tbl_access_chk #(
  .PAGE_W(PAGE_W),
  .EA_W  (EA_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_op       (req_op),
  .req_byte     (req_byte),
  .req_page     (req_page),
  .req_ea       (req_ea),
  .cfg_wr_en    (cfg_wr_en),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .rsp_cfg_space(rsp_cfg_space),
  .wr_err       (wr_err)
);

// File: tb/tbl_access_unit_test.sv
module tbl_access_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 4;
  localparam int DEPTH      = 1 << IDX_W;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic        req_byte;
  logic [7:0]  req_page;
  logic [15:0] req_ea;
  logic [15:0] req_wdata;
  logic        cfg_wr_en;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        rsp_cfg_space;
  logic        wr_err;

  int vectors;
  int miscompares;
  int serial;
  bit finished;

  logic [23:0] model [2][DEPTH];

  tbl_access_unit #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_byte(req_byte), .req_page(req_page), .req_ea(req_ea),
    .req_wdata(req_wdata), .cfg_wr_en(cfg_wr_en), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_cfg_space(rsp_cfg_space), .wr_err(wr_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [23:0] w, input logic hi,
                                           input logic byt, input logic sel);
    if (!hi) begin
      if (!byt) return w[15:0];
      return sel ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    end
    if (byt && sel) return 16'h0000;
    return {8'h00, w[23:16]};
  endfunction

  // Issues one request and returns the response seen in the next cycle.
  task automatic issue(input logic [1:0] op, input logic byt, input logic [7:0] pg,
                       input logic [15:0] ea, input logic [15:0] wd, input logic wen,
                       output logic vld, output logic [15:0] rd, output logic cs,
                       output logic err);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_byte = byt; req_page = pg;
    req_ea = ea; req_wdata = wd; cfg_wr_en = wen;
    @(negedge clk);
    req_valid = 1'b0;
    vld = rsp_valid; rd = rsp_rdata; cs = rsp_cfg_space; err = wr_err;
  endtask

  function automatic logic [7:0] page_of(input int s);
    return {1'(s), 7'(serial * 3 + 1)};
  endfunction

  function automatic logic [15:0] ea_of(input int idx, input logic b0);
    return {11'(serial * 7 + 5), 4'(idx), b0};
  endfunction

  task automatic readback(input int s, input int idx);
    logic v, c, e;
    logic [15:0] d;
    serial++;
    issue(2'b00, 1'b0, page_of(s), ea_of(idx, 1'(serial)), 16'hffff, 1'b0, v, d, c, e);
    check(v && d == model[s][idx][15:0], "R3/R4/R8 low word readback",
          {15'd0, v, d}, {16'd1, model[s][idx][15:0]});
    serial++;
    issue(2'b01, 1'b0, page_of(s), ea_of(idx, 1'(serial)), 16'hffff, 1'b0, v, d, c, e);
    check(v && d == {8'h00, model[s][idx][23:16]}, "R3/R6/R9 high word readback",
          {15'd0, v, d}, {16'd1, 8'h00, model[s][idx][23:16]});
  endtask

  initial begin
    finished = 1'b0;
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic v, c, e;
    logic [15:0] d;
    vectors = 0; miscompares = 0; serial = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_byte = 1'b0;
    req_page = 8'h00; req_ea = 16'h0000; req_wdata = 16'h0000; cfg_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    check(!rsp_valid && !wr_err && rsp_rdata == 16'h0, "R1 reset state",
          {rsp_valid, wr_err, rsp_rdata}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rsp_valid && !wr_err && rsp_rdata == 16'h0, "R1 idle after reset",
          {rsp_valid, wr_err, rsp_rdata}, 32'h0);

    // Fill both regions with known contents.
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < DEPTH; i++) begin
        model[s][i] = 24'(i * 24'h05a3c1 + s * 24'h3c0f55 + 24'h123456);
        serial++;
        issue(2'b10, 1'b0, page_of(s), ea_of(i, 1'b0), model[s][i][15:0], 1'b1, v, d, c, e);
        serial++;
        issue(2'b11, 1'b0, page_of(s), ea_of(i, 1'b1), {8'h5a, model[s][i][23:16]},
              1'b1, v, d, c, e);
      end
    end

    for (int wen = 0; wen < 2; wen++) begin
      for (int op = 0; op < 4; op++) begin
        for (int byt = 0; byt < 2; byt++) begin
          for (int sel = 0; sel < 2; sel++) begin
            for (int s = 0; s < 2; s++) begin
              for (int i = 0; i < DEPTH; i++) begin
                logic [15:0] wd;
                logic        bsel;
                logic        blocked;
                serial++;
                wd      = 16'(serial * 16'h9e37 + 16'h1234);
                bsel    = 1'(byt) & 1'(sel);
                blocked = (s == 1) && (wen == 0);
                issue(2'(op), 1'(byt), page_of(s), ea_of(i, 1'(sel)), wd, 1'(wen),
                      v, d, c, e);
                check(v, "R2 response valid", {31'd0, v}, 32'd1);
                check(c == 1'(s), "R2 region flag", {31'd0, c}, s);
                if (op < 2) begin
                  check(d == exp_read(model[s][i], 1'(op), 1'(byt), bsel),
                        op == 0 ? (byt ? "R5 low byte read" : "R4 low word read")
                                : (byt ? "R7 high byte read" : "R6 high word read"),
                        {16'd0, d}, {16'd0, exp_read(model[s][i], 1'(op), 1'(byt), bsel)});
                  check(!e, "R10 no error on read", {31'd0, e}, 32'd0);
                end else begin
                  check(d == 16'h0, "R11 write response data", {16'd0, d}, 32'd0);
                  check(e == blocked, "R10 error pulse", {31'd0, e}, {31'd0, blocked});
                  if (!blocked) begin
                    if (op == 2) begin
                      if (!byt) model[s][i][15:0] = wd;
                      else if (bsel) model[s][i][15:8] = wd[7:0];
                      else model[s][i][7:0] = wd[7:0];
                    end else if (!bsel) begin
                      model[s][i][23:16] = wd[7:0];
                    end
                  end
                  readback(s, i);
                  @(negedge clk);
                  check(!wr_err && !rsp_valid, "R10 error is single pulse",
                        {30'd0, wr_err, rsp_valid}, 32'd0);
                end
              end
            end
          end
        end
      end
    end

    // Back-to-back write then read with no idle cycle between them (R11).
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b10; req_byte = 1'b0; req_page = 8'h00;
    req_ea = 16'h0006; req_wdata = 16'hbeef; cfg_wr_en = 1'b0;
    @(negedge clk);
    req_op = 2'b00; req_wdata = 16'h0000;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_rdata == 16'hbeef, "R11 read right after write",
          {15'd0, rsp_valid, rsp_rdata}, {16'd1, 16'hbeef});

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule